// File: doc/BRIEF.md
# Redundant-Channel Coincidence Voter

This block combines the trip decisions of four redundant measurement channels into one initiation signal for each protective function. Each channel presents one trip bit per function. The block counts the trip bits of the channels that are in service. A function initiates when that count reaches the vote threshold, which is two by default. A single channel can be taken out of service through a bypass request. Its vote is then discarded and the same threshold applies over the three remaining channels. A request that would take a second channel out of service is refused and raises an error flag.

Functions that are marked as actuation-type in the seal-in mask latch their initiation. The output stays on after the channel trips return to normal, and it clears only on a manual reset issued once the coincidence has gone away. All other functions follow the vote with a latency of one clock. For each function the block reports how many channels are currently voting, so that supervisory logic can tell whether the voter is running as two-of-four or as two-of-three.

Top module: `cv_coincidence_voter`

## Requirements
- R1: With no channel bypassed, a function's initiation output is 1 one clock after at least 2 of the 4 channel trip bits for that function are 1, and 0 otherwise (non-latched function). Channel c's trip bit for function f is at trip_i[c*NUM_FUNC+f].
- R2: A single bypass request bit byp_req_i[c] bypasses channel c from the next clock onward. A bypassed channel's trip bits are ignored, and a function initiates when at least 2 of the 3 remaining channels trip.
- R3: With one channel bypassed and a second channel stuck tripped, a trip on either of the two other channels is enough to initiate the function.
- R4: With one channel bypassed and a second channel stuck non-tripped, the function initiates only when both of the other two channels trip.
- R5: For a function whose seal_en_i bit is 1, the initiation output stays 1 after the coincidence clears, for as long as no manual reset is given.
- R6: A manual reset (man_rst_i high at a clock edge) clears a sealed initiation output at that edge when the coincidence for that function is false.
- R7: A manual reset given while the coincidence for a function is still true leaves that function's initiation output at 1.
- R8: A function whose seal_en_i bit is 0 follows its vote with exactly one clock of latency and is never held.
- R9: When more than one bit of byp_req_i is 1, the accepted bypass stays as it was, and bypass_err_o is 1 from the next clock until the request is back to zero or one bits.
- R10: mode_o field f (bits f*3 +: 3) holds the number of channels that are not bypassed, which is 4 or 3.
- R11: After reset every initiation output is 0, no channel is bypassed, bypass_err_o is 0 and every mode field is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | NUM_CH*NUM_FUNC | Channel trip bits; channel c, function f at bit c*NUM_FUNC+f |
| byp_req_i | input | NUM_CH | Per-channel bypass request |
| seal_en_i | input | NUM_FUNC | Per-function seal-in (latching) enable |
| man_rst_i | input | 1 | Manual reset of sealed initiations |
| init_o | output | NUM_FUNC | Registered initiation output per function |
| mode_o | output | NUM_FUNC*CNT_W | Per-function count of voting channels |
| bypass_err_o | output | 1 | Registered flag for a refused multi-channel bypass request |

## Verification
A wrong accepted-bypass register shows up at mode_o one clock after the request. It also appears as a wrong initiation one clock after a trip pattern that tells the bypassed channel apart from the others. Errors in the vote count show up at init_o one clock after the offending trip pattern. A broken seal-in or reset gate shows up only later: a sealed output drops once the trips clear, or it survives a reset given with no coincidence. That is why the sequences run the output through clearing and reset both with and without the coincidence still present.

// File: rtl/cv_pkg.sv
package cv_pkg;

   // Number of set bits in a channel vector of up to 16 channels.
   function automatic int unsigned cv_popcount(input logic [15:0] vec);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 16; i++) begin
         n += int'(vec[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/cv_bypass_ctl.sv
module cv_bypass_ctl #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] byp_req_i,
   output logic [NUM_CH-1:0] byp_eff_o,
   output logic [CNT_W-1:0]  active_cnt_o,
   output logic              byp_err_o
);
   import cv_pkg::*;

   logic [15:0]       req_wide;
   logic [15:0]       eff_wide;
   logic              req_multi;
   logic [NUM_CH-1:0] byp_q;
   logic              err_q;

   assign req_wide  = 16'(byp_req_i);
   assign eff_wide  = 16'(byp_q);
   assign req_multi = (cv_popcount(req_wide) > 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= req_multi;
         if (!req_multi) begin
            byp_q <= byp_req_i;
         end
      end
   end

   assign byp_eff_o    = byp_q;
   assign byp_err_o    = err_q;
   assign active_cnt_o = CNT_W'(NUM_CH - int'(cv_popcount(eff_wide)));

   AST_SINGLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(byp_q));                                             // R9
   AST_MULTI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(byp_req_i) > 1) |=> ($stable(byp_q) && err_q));    // R9

endmodule

// File: rtl/cv_vote_slice.sv
module cv_vote_slice #(
   parameter int NUM_CH = 4,
   parameter int VOTE_K = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_trip_i,
   input  logic [NUM_CH-1:0] byp_i,
   input  logic              seal_en_i,
   input  logic              man_rst_i,
   output logic              init_o
);
   import cv_pkg::*;

   logic [NUM_CH-1:0] live_trip;
   logic              vote;
   logic              init_q;

   assign live_trip = ch_trip_i & ~byp_i;
   assign vote      = (cv_popcount(16'(live_trip)) >= VOTE_K);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
      end else if (!seal_en_i) begin
         init_q <= vote;
      end else if (vote) begin
         init_q <= 1'b1;
      end else if (man_rst_i) begin
         init_q <= 1'b0;
      end
   end

   assign init_o = init_q;

   AST_VOTE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      vote |=> init_q);                                             // R1
   AST_SEAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seal_en_i && init_q && !man_rst_i) |=> init_q);              // R5
   AST_RESET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (seal_en_i && man_rst_i && vote) |=> init_q);                 // R7
   AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!seal_en_i && !vote) |=> !init_q);                           // R8

endmodule

// File: rtl/cv_coincidence_voter.sv
module cv_coincidence_voter #(
   parameter int NUM_CH   = 4,
   parameter int NUM_FUNC = 4,
   parameter int VOTE_K   = 2,
   parameter int CNT_W    = $clog2(NUM_CH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH*NUM_FUNC-1:0] trip_i,
   input  logic [NUM_CH-1:0]          byp_req_i,
   input  logic [NUM_FUNC-1:0]        seal_en_i,
   input  logic                       man_rst_i,
   output logic [NUM_FUNC-1:0]        init_o,
   output logic [NUM_FUNC*CNT_W-1:0]  mode_o,
   output logic                       bypass_err_o
);

   if (VOTE_K < 1 || VOTE_K >= NUM_CH) begin : g_bad_k
      $error("VOTE_K must leave a voting quorum after one bypass");
   end
   if (NUM_CH > 16 || NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be between 2 and 16");
   end
   if (NUM_FUNC < 1) begin : g_bad_f
      $error("NUM_FUNC must be at least 1");
   end

   logic [NUM_CH-1:0] byp_eff;
   logic [CNT_W-1:0]  active_cnt;

   cv_bypass_ctl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_byp (
      .clk         (clk),
      .rst_n       (rst_n),
      .byp_req_i   (byp_req_i),
      .byp_eff_o   (byp_eff),
      .active_cnt_o(active_cnt),
      .byp_err_o   (bypass_err_o)
   );

   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
      logic [NUM_CH-1:0] ch_trip;
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign ch_trip[c] = trip_i[c*NUM_FUNC + f];
      end

      cv_vote_slice #(.NUM_CH(NUM_CH), .VOTE_K(VOTE_K)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .ch_trip_i(ch_trip),
         .byp_i    (byp_eff),
         .seal_en_i(seal_en_i[f]),
         .man_rst_i(man_rst_i),
         .init_o   (init_o[f])
      );

      assign mode_o[f*CNT_W +: CNT_W] = active_cnt;
   end

   AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[CNT_W-1:0] == CNT_W'(NUM_CH)) ||
      (mode_o[CNT_W-1:0] == CNT_W'(NUM_CH - 1)));                   // R10

endmodule

// File: tb/cv_coincidence_voter_tb.sv
module cv_coincidence_voter_tb;
   localparam int NC = 4;
   localparam int NF = 4;
   localparam int CW = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NC*NF-1:0] trip = '0;
   logic [NC-1:0]    byp_req = '0;
   logic [NF-1:0]    seal = '0;
   logic             mrst = 1'b0;
   logic [NF-1:0]    init;
   logic [NF*CW-1:0] mode;
   logic             berr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cv_coincidence_voter #(.NUM_CH(NC), .NUM_FUNC(NF), .VOTE_K(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .trip_i(trip), .byp_req_i(byp_req),
      .seal_en_i(seal), .man_rst_i(mrst), .init_o(init), .mode_o(mode),
      .bypass_err_o(berr)
   );

   function automatic logic [NC*NF-1:0] pack(input logic [3:0] n0, input logic [3:0] n1,
                                             input logic [3:0] n2, input logic [3:0] n3);
      logic [NC*NF-1:0] v;
      for (int c = 0; c < NC; c++) begin
         v[c*NF+0] = n0[c];
         v[c*NF+1] = n1[c];
         v[c*NF+2] = n2[c];
         v[c*NF+3] = n3[c];
      end
      return v;
   endfunction

   function automatic logic exp_vote(input logic [3:0] tr, input logic [3:0] by);
      int n;
      n = 0;
      for (int c = 0; c < NC; c++) if (tr[c] && !by[c]) n++;
      return (n >= 2);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_mode(input string req, input int exp);
      for (int f = 0; f < NF; f++) chk(req, int'(mode[f*CW +: CW]), exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] nib [4];
      logic [3:0] bv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R11 reset state
      chk("R11 init", int'(init), 0);
      chk("R11 err", int'(berr), 0);
      chk_mode("R11 mode", 4);

      // R1/R2/R10 sweep over every trip pattern and every bypass choice
      for (int bi = 0; bi <= 4; bi++) begin
         bv = (bi == 4) ? 4'b0000 : 4'(1 << bi);
         trip = '0;
         byp_req = bv;
         tick();
         chk_mode("R10 mode", (bi == 4) ? 4 : 3);
         chk("R10 err", int'(berr), 0);
         for (int t = 0; t < 16; t++) begin
            nib[0] = 4'(t);
            nib[1] = ~4'(t);
            nib[2] = 4'(t) ^ 4'h5;
            nib[3] = {nib[0][0], nib[0][3:1]};
            trip = pack(nib[0], nib[1], nib[2], nib[3]);
            tick();
            for (int f = 0; f < NF; f++)
               chk((bi == 4) ? "R1 vote" : "R2 vote", int'(init[f]),
                   int'(exp_vote(nib[f], bv)));
         end
      end

      // R3: ch1 bypassed, ch2 stuck tripped; one more trip initiates
      byp_req = 4'b0010;
      trip = pack(4'b0100, 0, 0, 0);
      tick();
      tick();
      chk("R3 stuck alone", int'(init[0]), 0);
      trip = pack(4'b1100, 0, 0, 0);
      tick();
      chk("R3 one more ch3", int'(init[0]), 1);
      trip = pack(4'b0101, 0, 0, 0);
      tick();
      chk("R3 one more ch0", int'(init[0]), 1);
      // R4: ch1 bypassed, ch2 stuck low; need both ch0 and ch3
      trip = pack(4'b0011, 0, 0, 0);
      tick();
      chk("R4 ch0 only", int'(init[0]), 0);
      trip = pack(4'b1001, 0, 0, 0);
      tick();
      chk("R4 ch0+ch3", int'(init[0]), 1);

      // R9: second bypass request refused, ch1 bypass kept
      byp_req = 4'b0110;
      trip = '0;
      tick();
      chk("R9 err", int'(berr), 1);
      chk_mode("R9 mode", 3);
      trip = pack(4'b0101, 0, 0, 0);
      tick();
      chk("R9 ch2 still votes", int'(init[0]), 1);
      trip = pack(4'b0011, 0, 0, 0);
      tick();
      chk("R9 ch1 still bypassed", int'(init[0]), 0);
      byp_req = 4'b0000;
      trip = '0;
      tick();
      chk("R9 err clears", int'(berr), 0);
      chk_mode("R10 mode restored", 4);

      // R5/R6/R7/R8 seal-in on function 0 only
      seal = 4'b0001;
      trip = pack(4'b0011, 4'b0011, 0, 0);
      tick();
      chk("R5 set", int'(init[0]), 1);
      chk("R8 set", int'(init[1]), 1);
      trip = '0;
      tick();
      chk("R5 held", int'(init[0]), 1);
      chk("R8 follows", int'(init[1]), 0);
      tick();
      chk("R5 still held", int'(init[0]), 1);
      trip = pack(4'b0101, 0, 0, 0);
      mrst = 1'b1;
      tick();
      chk("R7 reset blocked", int'(init[0]), 1);
      trip = '0;
      mrst = 1'b0;
      tick();
      chk("R7 still sealed", int'(init[0]), 1);
      mrst = 1'b1;
      tick();
      chk("R6 reset clears", int'(init[0]), 0);
      mrst = 1'b0;
      tick();
      chk("R6 stays clear", int'(init[0]), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule